// File: doc/BRIEF.md
# Cluster VP Run/Stop Controller

This block starts and halts the virtual processors (VPs) of one cluster and keeps a bitmap of which of them are running. Software drives it through a small register bus: a write to the run register starts every named VP that is idle, and a write to the stop register halts every named VP that is running. Reading the status register returns the running bitmap. The same three registers answer in two address windows, one for the local cluster and one for access from another core.

For each VP there is a one-cycle start-reset pulse and a one-cycle halt-request pulse, and both are registered. After a synchronous reset, all VPs are stopped. In the first cycle after reset is released, the VPs chosen by the `START_RUNNING` parameter are started through the same path that a run write uses. An elaboration check rejects a `START_RUNNING` value that names a VP beyond `NUM_VP`.

Top module: `vpc_top`

## Requirements
- R1: While `rst` is high, `vp_reset`, `vp_halt` and `bus_rdata` are all zero, and the running bitmap clears to zero.
- R2: In the first cycle after `rst` falls, every VP whose bit is set in `START_RUNNING` receives a one-cycle `vp_reset` pulse, and its running bit becomes 1.
- R3: A write to the run register gives each VP whose data bit is 1 and that is idle a `vp_reset` pulse in the cycle after the write. Its running bit is set in that same cycle, and the pulse lasts exactly one cycle.
- R4: A write to the stop register gives each VP whose data bit is 1 and that is running a one-cycle `vp_halt` pulse in the cycle after the write. Its running bit is cleared in that same cycle.
- R5: A run bit for a VP that is already running, or a stop bit for a VP that is already idle, produces no pulse and leaves that VP's running bit unchanged.
- R6: Write data bits at positions `NUM_VP` and above have no effect on either command.
- R7: Presenting the status address produces, one cycle later on `bus_rdata`, the running bitmap (bit i = VP i), zero-extended to 64 bits. A write to the status address changes nothing.
- R8: The run register sits at offset 0x28, stop at 0x20 and status at 0x30. Each offset answers both at base 0x2000 and at base 0x4000.
- R9: A read from any other address returns zero one cycle later. A write to any other address produces no pulse and leaves the running bitmap unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wen | input | 1 | Write strobe for the current address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data for the previous cycle's address |
| vp_reset | output | NUM_VP | One-cycle start-reset pulse per VP |
| vp_halt | output | NUM_VP | One-cycle halt-request pulse per VP |

## Verification
The bench targets the masking corners. It issues a run write that names one running VP and one idle VP, where a design without the idle filter would reset a live core. It issues a stop write to a VP that is already idle, where a wrong design would send a spurious halt. It issues writes whose data has only high bits set, where a design without the `NUM_VP` mask would touch nonexistent VPs or misreport status. It reaches each register through both windows, and it writes the status address and unmapped addresses. A decoder with a wrong base or offset would then miss a command or act on a stray one. The bench also checks the boot start right after reset release, which a design that ignored `START_RUNNING` or delayed the boot start would get wrong, and it confirms that every pulse drops after one cycle.

// File: rtl/vpc_pkg.sv
package vpc_pkg;
  typedef enum logic [1:0] {
    REG_NONE = 2'd0,
    REG_RUN  = 2'd1,
    REG_STOP = 2'd2,
    REG_STAT = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/vpc_decode.sv
module vpc_decode #(
  parameter int          ADDR_W     = 16,
  parameter logic [15:0] LOCAL_BASE = 16'h2000,
  parameter logic [15:0] OTHER_BASE = 16'h4000,
  parameter logic [15:0] OFS_RUN    = 16'h0028,
  parameter logic [15:0] OFS_STOP   = 16'h0020,
  parameter logic [15:0] OFS_STAT   = 16'h0030
) (
  input  logic [ADDR_W-1:0] addr,
  output vpc_pkg::reg_sel_e sel
);
  localparam int NWIN = 2;
  localparam logic [15:0] BASES [NWIN] = '{LOCAL_BASE, OTHER_BASE};

  logic [NWIN-1:0] hit_run, hit_stop, hit_stat;

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    assign hit_run[w]  = (addr == ADDR_W'(BASES[w] + OFS_RUN));
    assign hit_stop[w] = (addr == ADDR_W'(BASES[w] + OFS_STOP));
    assign hit_stat[w] = (addr == ADDR_W'(BASES[w] + OFS_STAT));
  end

  always_comb begin
    sel = vpc_pkg::REG_NONE;
    if (|hit_run)       sel = vpc_pkg::REG_RUN;
    else if (|hit_stop) sel = vpc_pkg::REG_STOP;
    else if (|hit_stat) sel = vpc_pkg::REG_STAT;
  end
endmodule

// File: rtl/vpc_slice.sv
module vpc_slice (
  input  logic clk,
  input  logic rst,
  input  logic run_req,
  input  logic stop_req,
  output logic running,
  output logic rst_pulse,
  output logic halt_pulse
);
  always_ff @(posedge clk) begin
    if (rst) begin
      running    <= 1'b0;
      rst_pulse  <= 1'b0;
      halt_pulse <= 1'b0;
    end else begin
      rst_pulse  <= run_req && !running;
      halt_pulse <= stop_req && running;
      if (run_req && !running)      running <= 1'b1;
      else if (stop_req && running) running <= 1'b0;
    end
  end

  p_start_idle_r3: assert property (@(posedge clk) disable iff (rst)
    (run_req && !stop_req && !running) |=> (rst_pulse && running));
  p_halt_running_r4: assert property (@(posedge clk) disable iff (rst)
    (stop_req && !run_req && running) |=> (halt_pulse && !running));
  p_run_noop_r5: assert property (@(posedge clk) disable iff (rst)
    (run_req && running && !stop_req) |=> (!rst_pulse && running));
  p_stop_noop_r5: assert property (@(posedge clk) disable iff (rst)
    (stop_req && !running && !run_req) |=> (!halt_pulse && !running));
  p_pulse_single_r3: assert property (@(posedge clk) disable iff (rst)
    rst_pulse |=> !rst_pulse);
endmodule

// File: rtl/vpc_readmux.sv
module vpc_readmux #(
  parameter int NUM_VP = 1,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stat_hit,
  input  logic [NUM_VP-1:0] running,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] ext;

  always_comb begin
    ext = '0;
    ext[NUM_VP-1:0] = running;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= stat_hit ? ext : '0;
  end

  p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (rst)
    !stat_hit |=> (rdata == '0));
  p_status_value_r7: assert property (@(posedge clk) disable iff (rst)
    stat_hit |=> (rdata[NUM_VP-1:0] == $past(running)));
endmodule

// File: rtl/vpc_top.sv
module vpc_top #(
  parameter int          NUM_VP        = 1,
  parameter logic [63:0] START_RUNNING = 64'h1,
  parameter int          ADDR_W        = 16,
  parameter int          DATA_W        = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wen,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NUM_VP-1:0] vp_reset,
  output logic [NUM_VP-1:0] vp_halt
);
  localparam logic [63:0] VALID_MASK = (NUM_VP >= 64) ? '1 : ((64'd1 << NUM_VP) - 64'd1);
  localparam logic [NUM_VP-1:0] BOOT_SET = START_RUNNING[NUM_VP-1:0];

  if (NUM_VP < 1 || NUM_VP > 64 || NUM_VP > DATA_W) begin : g_bad_count
    $error("vpc_top: NUM_VP out of range");
  end
  if ((START_RUNNING & ~VALID_MASK) != 64'd0) begin : g_bad_start
    $error("vpc_top: START_RUNNING names a VP beyond NUM_VP");
  end

  vpc_pkg::reg_sel_e sel;
  logic              boot_q;
  logic [NUM_VP-1:0] run_vec, stop_vec, running;
  logic              unused_wdata;

  assign unused_wdata = ^bus_wdata;

  vpc_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (bus_addr),
    .sel  (sel)
  );

  always_ff @(posedge clk) begin
    if (rst) boot_q <= 1'b1;
    else     boot_q <= 1'b0;
  end

  always_comb begin
    run_vec  = boot_q ? BOOT_SET : '0;
    stop_vec = '0;
    if (bus_wen && sel == vpc_pkg::REG_RUN)  run_vec  = run_vec | bus_wdata[NUM_VP-1:0];
    if (bus_wen && sel == vpc_pkg::REG_STOP) stop_vec = bus_wdata[NUM_VP-1:0];
  end

  for (genvar i = 0; i < NUM_VP; i++) begin : g_vp
    vpc_slice u_slice (
      .clk        (clk),
      .rst        (rst),
      .run_req    (run_vec[i]),
      .stop_req   (stop_vec[i]),
      .running    (running[i]),
      .rst_pulse  (vp_reset[i]),
      .halt_pulse (vp_halt[i])
    );
  end

  vpc_readmux #(.NUM_VP(NUM_VP), .DATA_W(DATA_W)) u_rd (
    .clk      (clk),
    .rst      (rst),
    .stat_hit (sel == vpc_pkg::REG_STAT),
    .running  (running),
    .rdata    (bus_rdata)
  );

  p_boot_start_r2: assert property (@(posedge clk) disable iff (rst)
    boot_q |=> ((vp_reset & BOOT_SET) == BOOT_SET));
  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(rst) |-> (vp_reset == '0 && vp_halt == '0 && bus_rdata == '0));
  p_no_cross_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    (vp_reset & vp_halt) == '0);
endmodule

// File: tb/vpc_top_tb.sv
module vpc_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 4;
  localparam logic [63:0] BOOT = 64'h5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] bus_addr = '0;
  logic        bus_wen = 1'b0;
  logic [63:0] bus_wdata = '0;
  logic [63:0] bus_rdata;
  logic [NV-1:0] vp_reset, vp_halt;

  int n_tests = 0;
  int n_fail  = 0;
  logic [NV-1:0] model_run;

  always #(CLK_PERIOD/2) clk = ~clk;

  vpc_top #(.NUM_VP(NV), .START_RUNNING(BOOT)) u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wen(bus_wen),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .vp_reset(vp_reset), .vp_halt(vp_halt)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic read_chk(input logic [15:0] a, input logic [63:0] exp, input string tag);
    @(negedge clk);
    bus_addr = a; bus_wen = 1'b0;
    @(negedge clk);
    check(tag, bus_rdata, exp);
    bus_addr = 16'h0;
  endtask

  task automatic write_chk(input logic [15:0] a, input logic [63:0] d,
                           input logic [NV-1:0] exp_rst, input logic [NV-1:0] exp_halt,
                           input string tag);
    @(negedge clk);
    bus_addr = a; bus_wen = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_wen = 1'b0; bus_addr = 16'h0; bus_wdata = '0;
    check({tag, " reset pulse"}, 64'(vp_reset), 64'(exp_rst));
    check({tag, " halt pulse"},  64'(vp_halt),  64'(exp_halt));
    @(negedge clk);
    check({tag, " pulses drop"}, 64'({vp_reset, vp_halt}), 64'd0);
  endtask

  task automatic t_reset_boot;
    rst = 1'b1;
    bus_addr = 16'h2030;
    repeat (3) @(negedge clk);
    check("R1 reset pulses", 64'({vp_reset, vp_halt}), 64'd0);
    check("R1 reset rdata", bus_rdata, 64'd0);
    rst = 1'b0;
    bus_addr = 16'h0;
    @(negedge clk);
    check("R2 boot reset pulse", 64'(vp_reset), BOOT);
    check("R2 boot no halt", 64'(vp_halt), 64'd0);
    @(negedge clk);
    check("R2 boot pulse one cycle", 64'(vp_reset), 64'd0);
    model_run = NV'(BOOT);
    read_chk(16'h2030, 64'(model_run), "R2 R7 boot status");
  endtask

  task automatic t_run_mixed;
    write_chk(16'h2028, 64'hB, 4'hA, 4'h0, "R3 R5 run mixed");
    model_run = 4'hF;
    read_chk(16'h2030, 64'(model_run), "R3 status after run");
  endtask

  task automatic t_stop_other;
    write_chk(16'h4020, 64'h3, 4'h0, 4'h3, "R4 R8 stop other window");
    model_run = 4'hC;
    read_chk(16'h4030, 64'(model_run), "R4 R8 status other window");
  endtask

  task automatic t_stop_idle;
    write_chk(16'h2020, 64'h1, 4'h0, 4'h0, "R5 stop idle");
    read_chk(16'h2030, 64'(model_run), "R5 status unchanged");
  endtask

  task automatic t_high_bits;
    write_chk(16'h4028, 64'hFFFF_FFFF_FFFF_FFF0, 4'h0, 4'h0, "R6 run high bits");
    read_chk(16'h2030, 64'(model_run), "R6 status after high run");
    write_chk(16'h2020, 64'hF000_0000_0000_00F4, 4'h0, 4'h4, "R6 stop high bits");
    model_run = 4'h8;
    read_chk(16'h2030, 64'(model_run), "R6 status after stop");
  endtask

  task automatic t_unmapped;
    write_chk(16'h2030, 64'hF, 4'h0, 4'h0, "R7 write status ignored");
    write_chk(16'h3028, 64'hF, 4'h0, 4'h0, "R9 write unmapped run");
    write_chk(16'h4024, 64'hF, 4'h0, 4'h0, "R9 write unmapped near stop");
    read_chk(16'h2030, 64'(model_run), "R9 status unchanged");
    read_chk(16'h1234, 64'd0, "R9 unmapped read");
    read_chk(16'h4028, 64'd0, "R9 run register reads zero");
  endtask

  task automatic t_run_other;
    write_chk(16'h4028, 64'h1, 4'h1, 4'h0, "R8 run other window");
    model_run = 4'h9;
    read_chk(16'h4030, 64'(model_run), "R8 R7 status");
  endtask

  initial begin
    t_reset_boot();
    t_run_mixed();
    t_stop_other();
    t_stop_idle();
    t_high_bits();
    t_unmapped();
    t_run_other();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule